// File: doc/BRIEF.md
# Saturating Guarded Accumulator Bank

A bank of four 40-bit signed accumulators for fixed-point multiply-accumulate and add work. Each accumulator holds a 32-bit signed body with 8 guard bits above it. The guard bits give headroom, so a long run of sums can grow past the 32-bit range without wrapping. Each cycle one operation can load, add to, or subtract from one selected accumulator. The addend is a signed 40-bit value. Q15 or Q31 products are sign-extended to 40 bits upstream. The result is registered and appears on the outputs after the next rising clock edge.

A global saturation mode decides what happens when a result leaves the signed 32-bit range. With the mode on, the result is clamped to the largest positive or the most negative 32-bit value, held in the 40-bit register. With the mode off, the full 40-bit result is kept. In both modes, leaving the 32-bit range sets a sticky overflow flag for that accumulator. A flag is cleared by reset, by an explicit clear mask, or by a conditional test that reads it. A new overflow in the same cycle as a clear takes priority, so the flag stays set.

Top module: `sat_acc_bank`

## Requirements
- R1: There are four accumulators, each 40 bits wide. Accumulator k occupies `acc_o[40k+39:40k]`. Inside it, bits [39:32] are guard bits, [31:16] are the high word and [15:0] are the low word. Reset clears every accumulator and every flag to zero and turns saturation mode off.
- R2: `op_code_i` selects the operation:
  - 2'b00 loads the addend.
  - 2'b01 adds the addend.
  - 2'b10 subtracts the addend from the accumulator.
  - 2'b11 changes nothing.

  The operation applies only while `op_valid_i` is high, and only to the accumulator chosen by `op_sel_i`. The new value is visible after the next rising edge. All other accumulators keep their values.
- R3: With saturation mode on, a result above 2^31-1 is stored as 0x00_7FFF_FFFF and a result below -2^31 is stored as 0xFF_8000_0000. A result inside that range is stored unchanged.
- R4: With saturation mode off, the result keeps all 40 bits. It wraps only when it leaves the 40-bit signed range. For example, 300 additions of 2^30 produce exactly 300·2^30.
- R5: The overflow flag of the operated accumulator (`ovf_o[k]`) is set when the full-precision result leaves the signed 32-bit range [-2^31, 2^31-1]. This holds in both modes. Op code 2'b11 never sets a flag.
- R6: An overflow flag stays set on later cycles until one of three things happens: reset, a 1 in its bit of `flag_clr_i`, or a conditional test of it.
- R7: While `test_valid_i` is high, `test_flag_o` shows, in the same cycle, the flag of the accumulator selected by `test_sel_i`. That flag is cleared at the next rising edge. While `test_valid_i` is low, `test_flag_o` is 0.
- R8: If an overflow occurs on an accumulator in the same cycle as a test or an explicit clear of its flag, the flag stays set.
- R9: A pulse on `sat_set_i` turns saturation mode on and a pulse on `sat_clr_i` turns it off. If both are high in the same cycle, set wins. The change takes effect from the next cycle. An operation in the same cycle as the strobe uses the old mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid_i | input | 1 | Operation strobe |
| op_sel_i | input | 2 | Accumulator index for the operation |
| op_code_i | input | 2 | 00 load, 01 add, 10 subtract, 11 no change |
| op_addend_i | input | 40 | Signed addend |
| sat_set_i | input | 1 | Turn saturation mode on |
| sat_clr_i | input | 1 | Turn saturation mode off |
| flag_clr_i | input | 4 | Per-accumulator explicit flag clear |
| test_valid_i | input | 1 | Conditional test of one flag |
| test_sel_i | input | 2 | Index of the tested flag |
| test_flag_o | output | 1 | Value of the tested flag |
| acc_o | output | 160 | All accumulators, accumulator k at bits [40k+39:40k] |
| ovf_o | output | 4 | Sticky overflow flags |
| sat_mode_o | output | 1 | Current saturation mode |

## Verification
Two pairs of functions can land in the same cycle:
- An overflowing operation on an accumulator, together with a conditional test or an explicit clear of that same accumulator's flag.
- A saturation-mode strobe, together with an overflowing operation.

The bench drives each pair in one cycle: an accumulator already at a limit is pushed past the limit while its flag is tested or cleared, and a mode set is issued alongside an overflowing add. A behavioural model computes the expected result. It checks that the flag survives the collision and that the operation in the strobe cycle still used the old mode, so the value is stored unclamped.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

   typedef enum logic [1:0] {
      OP_LOAD = 2'b00,
      OP_ADD  = 2'b01,
      OP_SUB  = 2'b10,
      OP_HOLD = 2'b11
   } sacc_op_e;

endpackage

// File: rtl/sacc_arith.sv
module sacc_arith
   import sacc_pkg::*;
#(
   parameter int ACC_W  = 40,
   parameter int BODY_W = 32,
   parameter bit SAT_EN = 1'b1
) (
   input  logic [ACC_W-1:0] cur_i,
   input  logic [ACC_W-1:0] addend_i,
   input  sacc_op_e         op_i,
   input  logic             sat_mode_i,
   output logic [ACC_W-1:0] res_o,
   output logic             ovf_o
);
   localparam int EXT_W   = ACC_W + 1;
   localparam int GUARD_W = ACC_W - BODY_W;
   localparam int TOP_W   = EXT_W - BODY_W + 1;
   localparam logic [ACC_W-1:0] POS_LIM = {{(GUARD_W + 1){1'b0}}, {(BODY_W - 1){1'b1}}};
   localparam logic [ACC_W-1:0] NEG_LIM = {{(GUARD_W + 1){1'b1}}, {(BODY_W - 1){1'b0}}};

   logic [EXT_W-1:0] cur_x;
   logic [EXT_W-1:0] add_x;
   logic [EXT_W-1:0] full;
   logic [TOP_W-1:0] top_bits;
   logic             out_range;

   assign cur_x = {cur_i[ACC_W-1], cur_i};
   assign add_x = {addend_i[ACC_W-1], addend_i};

   always_comb begin
      case (op_i)
         OP_LOAD: full = add_x;
         OP_ADD:  full = cur_x + add_x;
         OP_SUB:  full = cur_x - add_x;
         default: full = cur_x;
      endcase
   end

   // Result fits the signed body only when the sign and every bit above it agree.
   assign top_bits  = full[EXT_W-1:BODY_W-1];
   assign out_range = !((&top_bits) || !(|top_bits));
   assign ovf_o     = (op_i != OP_HOLD) && out_range;

   generate
      if (SAT_EN) begin : g_clamp
         always_comb begin
            if (sat_mode_i && ovf_o)
               res_o = full[EXT_W-1] ? NEG_LIM : POS_LIM;
            else
               res_o = full[ACC_W-1:0];
         end
      end else begin : g_wrap
         logic unused_mode;
         assign unused_mode = sat_mode_i;
         assign res_o       = full[ACC_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/sacc_flag_cell.sv
module sacc_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   // A fresh overflow outranks any clear in the same cycle.
   always_ff @(posedge clk) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else if (set_i)
         flag_o <= 1'b1;
      else if (clr_i)
         flag_o <= 1'b0;
   end
endmodule

// File: rtl/sacc_mode_reg.sv
module sacc_mode_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic on_i,
   input  logic off_i,
   output logic mode_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_o <= 1'b0;
      else if (on_i)
         mode_o <= 1'b1;
      else if (off_i)
         mode_o <= 1'b0;
   end
endmodule

// File: rtl/sat_acc_bank.sv
module sat_acc_bank
   import sacc_pkg::*;
#(
   parameter int NUM_ACC = 4,
   parameter int ACC_W   = 40,
   parameter int BODY_W  = 32,
   parameter bit SAT_EN  = 1'b1,
   localparam int SEL_W  = $clog2(NUM_ACC)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     op_valid_i,
   input  logic [SEL_W-1:0]         op_sel_i,
   input  logic [1:0]               op_code_i,
   input  logic [ACC_W-1:0]         op_addend_i,
   input  logic                     sat_set_i,
   input  logic                     sat_clr_i,
   input  logic [NUM_ACC-1:0]       flag_clr_i,
   input  logic                     test_valid_i,
   input  logic [SEL_W-1:0]         test_sel_i,
   output logic                     test_flag_o,
   output logic [NUM_ACC*ACC_W-1:0] acc_o,
   output logic [NUM_ACC-1:0]       ovf_o,
   output logic                     sat_mode_o
);

   // Elaboration-time parameter checks
   if (NUM_ACC < 2 || (1 << SEL_W) != NUM_ACC) begin : g_bad_count
      $error("sat_acc_bank: NUM_ACC must be a power of two, at least 2");
   end
   if (BODY_W < 2) begin : g_bad_body
      $error("sat_acc_bank: BODY_W must be at least 2");
   end
   if (ACC_W <= BODY_W) begin : g_bad_guard
      $error("sat_acc_bank: ACC_W must leave guard bits above BODY_W");
   end

   sacc_op_e         op_eff;
   logic [ACC_W-1:0] cur_sel;
   logic [ACC_W-1:0] res;
   logic             ovf_now;

   assign op_eff  = op_valid_i ? sacc_op_e'(op_code_i) : OP_HOLD;
   assign cur_sel = acc_o[op_sel_i*ACC_W +: ACC_W];

   sacc_mode_reg u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .on_i   (sat_set_i),
      .off_i  (sat_clr_i),
      .mode_o (sat_mode_o)
   );

   sacc_arith #(
      .ACC_W  (ACC_W),
      .BODY_W (BODY_W),
      .SAT_EN (SAT_EN)
   ) u_arith (
      .cur_i      (cur_sel),
      .addend_i   (op_addend_i),
      .op_i       (op_eff),
      .sat_mode_i (sat_mode_o),
      .res_o      (res),
      .ovf_o      (ovf_now)
   );

   generate
      for (genvar k = 0; k < NUM_ACC; k++) begin : g_acc
         logic             hit;
         logic             test_hit;
         logic [ACC_W-1:0] acc_q;

         assign hit      = (op_eff != OP_HOLD) && (op_sel_i == SEL_W'(k));
         assign test_hit = test_valid_i && (test_sel_i == SEL_W'(k));

         always_ff @(posedge clk) begin
            if (!rst_n)
               acc_q <= '0;
            else if (hit)
               acc_q <= res;
         end

         assign acc_o[k*ACC_W +: ACC_W] = acc_q;

         sacc_flag_cell u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (hit && ovf_now),
            .clr_i  (flag_clr_i[k] || test_hit),
            .flag_o (ovf_o[k])
         );
      end
   endgenerate

   assign test_flag_o = test_valid_i && ovf_o[test_sel_i];

endmodule

// File: rtl/sat_acc_bank_chk.sv
module sat_acc_bank_chk #(
   parameter int NUM_ACC = 4,
   parameter int ACC_W   = 40,
   parameter int BODY_W  = 32,
   localparam int SEL_W  = $clog2(NUM_ACC),
   localparam int TOP_W  = ACC_W - BODY_W + 1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     op_valid_i,
   input logic [SEL_W-1:0]         op_sel_i,
   input logic [1:0]               op_code_i,
   input logic                     sat_set_i,
   input logic                     sat_clr_i,
   input logic [NUM_ACC-1:0]       flag_clr_i,
   input logic                     test_valid_i,
   input logic [SEL_W-1:0]         test_sel_i,
   input logic                     test_flag_o,
   input logic [NUM_ACC*ACC_W-1:0] acc_o,
   input logic [NUM_ACC-1:0]       ovf_o,
   input logic                     sat_mode_o
);
   logic [SEL_W-1:0] sel_q;
   logic [SEL_W-1:0] tsel_q;
   logic [ACC_W-1:0] acc_at_sel;
   logic [TOP_W-1:0] sel_top;
   logic             sel_in_range;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= '0;
         tsel_q <= '0;
      end else begin
         sel_q  <= op_sel_i;
         tsel_q <= test_sel_i;
      end
   end

   assign acc_at_sel   = acc_o[sel_q*ACC_W +: ACC_W];
   assign sel_top      = acc_at_sel[ACC_W-1:BODY_W-1];
   assign sel_in_range = (&sel_top) || !(|sel_top);

   // R3: a saturating write leaves the written accumulator inside the body range
   p_sat_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && op_code_i != 2'b11 && sat_mode_o) |=> sel_in_range);

   // R9: mode strobes act on the next cycle, set outranks clear
   p_mode_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sat_set_i |=> sat_mode_o);
   p_mode_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_clr_i && !sat_set_i) |=> !sat_mode_o);

   // R7: a tested flag that saw no new operation is gone next cycle
   p_test_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (test_valid_i && test_flag_o && !(op_valid_i && op_sel_i == test_sel_i))
      |=> !ovf_o[tsel_q]);

   generate
      for (genvar k = 0; k < NUM_ACC; k++) begin : g_chk
         // R2: an accumulator not addressed by a real operation holds its value
         p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(op_valid_i && op_sel_i == SEL_W'(k) && op_code_i != 2'b11)
            |=> $stable(acc_o[k*ACC_W +: ACC_W]));

         // R6: a set flag with no clear and no test stays set
         p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_o[k] && !flag_clr_i[k] && !(test_valid_i && test_sel_i == SEL_W'(k)))
            |=> ovf_o[k]);

         // R5: a flag only rises after an operation on its own accumulator
         p_flag_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovf_o[k]) |-> $past(op_valid_i && op_sel_i == SEL_W'(k) && op_code_i != 2'b11));
      end
   endgenerate

endmodule

bind sat_acc_bank sat_acc_bank_chk #(
   .NUM_ACC (NUM_ACC),
   .ACC_W   (ACC_W),
   .BODY_W  (BODY_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_valid_i   (op_valid_i),
   .op_sel_i     (op_sel_i),
   .op_code_i    (op_code_i),
   .sat_set_i    (sat_set_i),
   .sat_clr_i    (sat_clr_i),
   .flag_clr_i   (flag_clr_i),
   .test_valid_i (test_valid_i),
   .test_sel_i   (test_sel_i),
   .test_flag_o  (test_flag_o),
   .acc_o        (acc_o),
   .ovf_o        (ovf_o),
   .sat_mode_o   (sat_mode_o)
);

// File: tb/sim_sat_acc_bank.sv
module sim_sat_acc_bank;
   localparam longint LIM_P = 64'sh7FFF_FFFF;
   localparam longint LIM_N = -64'sh8000_0000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         op_valid = 1'b0;
   logic [1:0]   op_sel = '0;
   logic [1:0]   op_code = '0;
   logic [39:0]  op_add = '0;
   logic         sset = 1'b0;
   logic         sclr = 1'b0;
   logic [3:0]   fclr = '0;
   logic         tvalid = 1'b0;
   logic [1:0]   tsel = '0;
   logic         test_flag;
   logic [159:0] acc;
   logic [3:0]   ovf;
   logic         mode;

   int n_chk = 0;
   int n_fail = 0;

   longint   m_acc [4];
   logic [3:0] m_flag;
   logic     m_mode;

   always #2 clk = ~clk;

   sat_acc_bank u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .op_valid_i   (op_valid),
      .op_sel_i     (op_sel),
      .op_code_i    (op_code),
      .op_addend_i  (op_add),
      .sat_set_i    (sset),
      .sat_clr_i    (sclr),
      .flag_clr_i   (fclr),
      .test_valid_i (tvalid),
      .test_sel_i   (tsel),
      .test_flag_o  (test_flag),
      .acc_o        (acc),
      .ovf_o        (ovf),
      .sat_mode_o   (mode)
   );

   function automatic longint wrap40(input longint v);
      longint t;
      t = v <<< 24;
      return t >>> 24;
   endfunction

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      for (int k = 0; k < 4; k++)
         chk(tag, $sformatf("acc%0d", k), longint'($signed(acc[k*40 +: 40])), m_acc[k]);
      chk(tag, "flags", longint'(ovf), longint'(m_flag));
      chk(tag, "mode", longint'(mode), longint'(m_mode));
   endtask

   task automatic idle_inputs();
      op_valid = 1'b0; op_code = 2'b11; op_sel = '0; op_add = '0;
      sset = 1'b0; sclr = 1'b0; fclr = '0; tvalid = 1'b0; tsel = '0;
   endtask

   task automatic set_op(input int sel, input int code, input longint add);
      op_valid = 1'b1;
      op_sel   = 2'(sel);
      op_code  = 2'(code);
      op_add   = add[39:0];
   endtask

   // One clock: check same-cycle test output, advance the model, compare after the edge.
   task automatic tick(input string tag);
      longint cur, full, res, addv;
      logic [3:0] nflag;
      logic ov;
      int s;
      #1;
      if (tvalid)
         chk(tag, "test_flag", longint'(test_flag), longint'(m_flag[tsel]));
      else
         chk(tag, "test_flag idle", longint'(test_flag), 0);
      nflag = m_flag;
      for (int k = 0; k < 4; k++)
         if (fclr[k] || (tvalid && tsel == 2'(k))) nflag[k] = 1'b0;
      if (op_valid && op_code != 2'b11) begin
         s    = int'(op_sel);
         cur  = m_acc[s];
         addv = longint'($signed(op_add));
         case (op_code)
            2'b00:   full = addv;
            2'b01:   full = cur + addv;
            default: full = cur - addv;
         endcase
         ov = (full > LIM_P) || (full < LIM_N);
         if (ov && m_mode) res = (full < 0) ? LIM_N : LIM_P;
         else              res = wrap40(full);
         m_acc[s] = res;
         if (ov) nflag[s] = 1'b1;
      end
      m_flag = nflag;
      if (sset)      m_mode = 1'b1;
      else if (sclr) m_mode = 1'b0;
      @(posedge clk);
      @(negedge clk);
      compare_all(tag);
      idle_inputs();
   endtask

   task automatic do_reset();
      idle_inputs();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      for (int k = 0; k < 4; k++) m_acc[k] = 0;
      m_flag = '0;
      m_mode = 1'b0;
      rst_n = 1'b1;
      compare_all("R1 reset");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      do_reset();

      // R2: basic operations and no-change code
      set_op(0, 0, 64'sh1234_5678);  tick("R2 load");
      set_op(0, 1, 64'sh10);         tick("R2 add");
      set_op(0, 2, 64'sh20);         tick("R2 sub");
      set_op(0, 3, 64'sh7FFF_FFFF);  tick("R2 nop");
      set_op(1, 0, -64'sd5);         tick("R2 load neg");

      // R4/R5: guard growth with saturation off
      set_op(2, 0, 0);               tick("R4 load");
      for (int i = 0; i < 300; i++) begin
         set_op(2, 1, 64'sh4000_0000);
         tick("R4 guard sum");
      end
      set_op(1, 0, 64'sh80_0000_0000); tick("R5 load 40-bit min");

      // R6: sticky, then explicit clear
      tick("R6 idle");
      tick("R6 idle");
      fclr = 4'b0100;                tick("R6 clear acc2");

      // R9 and R3: saturation on, clamps both ways, pass-through
      sset = 1'b1;                   tick("R9 set");
      set_op(3, 0, 64'sh7FFF_0000);  tick("R3 load");
      set_op(3, 1, 64'sh0010_0000);  tick("R3 clamp pos");
      set_op(0, 1, 64'sh100);        tick("R3 in range");
      set_op(0, 0, 64'sh12_0000_0000); tick("R3 load clamp");
      set_op(3, 0, -64'sh7FFF_0000); tick("R3 load neg");
      set_op(3, 2, 64'sh0100_0000);  tick("R3 clamp neg");

      // R7: conditional test reads and clears
      tvalid = 1'b1; tsel = 2'd3;    tick("R7 test set flag");
      tvalid = 1'b1; tsel = 2'd3;    tick("R7 test clear flag");
      tvalid = 1'b1; tsel = 2'd0;    tick("R7 test acc0");

      // R8: collisions of new overflow with test and with clear
      set_op(3, 2, 64'sh1); tvalid = 1'b1; tsel = 2'd3; tick("R8 test vs overflow");
      set_op(3, 2, 64'sh1); fclr = 4'b1000;             tick("R8 clear vs overflow");
      fclr = 4'b1000;                                   tick("R8 plain clear");

      // R9: priority, clear, and old mode used in strobe cycle
      sset = 1'b1; sclr = 1'b1;      tick("R9 both");
      sclr = 1'b1;                   tick("R9 clear");
      set_op(3, 2, 64'sh1);          tick("R9 off wraps body");
      set_op(2, 0, 64'sh7FFF_FFFF);  tick("R9 load");
      set_op(2, 1, 64'sh1); sset = 1'b1; tick("R9 old mode in strobe cycle");
      set_op(2, 1, 64'sh1);          tick("R9 new mode");

      // R1: reset after activity
      do_reset();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule